// File: doc/BRIEF.md
# Tick-Paced Serial Shift Engine

This block moves one word of 1 to 16 bits over a three-wire synchronous serial link: a serial clock it generates, a data output and a data input. The host first sets the edge mode, the bit order, the half-period and the transfer length through a small register port. It then writes the data word and issues a start command. The serial clock does not run from the system clock directly. Each of its half-periods lasts a programmed number of pulses on an external timebase enable, so the bit rate follows whatever timer drives that enable.

While the transfer runs, a down-counter tracks the bits still to go. The data register shifts out one bit per clock period and shifts the level seen on the input pin into the end it vacates. When the count is exhausted and the serial clock is back at its idle level, the engine drops busy and latches an interrupt flag. The flag stays set until the host clears it. The received word can then be read back from the data address.

Register port: a single address bus serves both writes (`wr_en` high) and combinational reads. The addresses are 0 = configuration, 1 = half-period, 2 = transfer size, 3 = data, and 4 = command/status.

Top module: `tick_serial_shifter`

## Requirements
- R1: After reset, `sclk`, `sdo` and `irq` are 0, status reads busy=0 and irq=0, and the configuration, half-period, size and data addresses all read 0.
- R2: During a transfer every high and low phase of `sclk` lasts exactly H pulses of `tick`, where H is the half-period register (address 1, legal range 1 to 0x8000). A stored value of 0 behaves as 1. Cycles without `tick` never move `sclk`.
- R3: With configuration bit 2 at 0, the word leaves least significant bit first: bit i is on `sdo` at the i-th data-valid edge.
- R4: With configuration bit 2 at 1, the word leaves most significant bit first: for length N, bit N-1-i is on `sdo` at the i-th data-valid edge.
- R5: The length N is the size register (address 2, bits 4:0). A value of 0 or above 16 gives N=16. A transfer is exactly N serial clock periods, which is 2*N*H ticks after the start command.
- R6: Configuration bits 1:0 pick the edge mode. 01 makes data valid on the falling edge, with `sclk` idling high. 10 makes data valid on the rising edge, with `sclk` idling low. `sdo` changes only at start and on edges that return `sclk` to idle.
- R7: The input pin is sampled on each data-valid edge. After completion the data address reads the received bits in positions N-1:0, each at the same position as the transmitted bit sent at that edge, and zeros above.
- R8: The tick that ends the last serial clock period returns `sclk` to idle. On that same edge, busy (status bit 0) drops and `irq` / status bit 1 sets.
- R9: `irq` stays set until the host writes 1 to command bit 1. If the clear and a completion fall in the same cycle, the flag ends set.
- R10: Writing 1 to command bit 0 starts a transfer only when idle. A start, or any configuration or data write, made while busy leaves the running transfer's timing, length, order and output bits unchanged.
- R11: A start command with edge mode 00 or 11 is ignored and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for writes and reads |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for `addr` |
| tick | input | 1 | Single-cycle timebase enable |
| sdi | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| irq | output | 1 | Transfer-complete interrupt flag |

## Verification
Two events can land in one cycle: the final half-period completing, which sets the interrupt, and the host's write-one-to-clear of that flag. The bench sets a half-period of one, so every tick is a clock edge and the bench knows which tick is the last. It drives the clear write together with that tick while the flag is already set from an earlier transfer. It then expects the status and the `irq` pin to read 1, and expects a later lone clear to bring them to 0. Start commands during a transfer are exercised the same way: they are interleaved with ticks, and the bench expects the serial clock pattern and the received word to stay unchanged.

// File: rtl/tss_pkg.sv
package tss_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_BAD  = 2'b11
    } edge_sel_e;

    localparam logic [2:0] A_CFG  = 3'd0;
    localparam logic [2:0] A_HALF = 3'd1;
    localparam logic [2:0] A_SIZE = 3'd2;
    localparam logic [2:0] A_DATA = 3'd3;
    localparam logic [2:0] A_CMD  = 3'd4;

endpackage

// File: rtl/tss_tick_divider.sv
module tss_tick_divider #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [HALF_W-1:0] half_i,
    output logic              edge_o
);

    typedef struct packed {
        logic [HALF_W-1:0] cnt;
    } div_st_t;

    div_st_t           st_d, st_q;
    logic [HALF_W-1:0] limit;

    always_comb begin
        limit  = (half_i == '0) ? HALF_W'(1) : half_i;
        st_d   = st_q;
        edge_o = run && tick && (st_q.cnt == limit - HALF_W'(1));
        if (!run) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = edge_o ? '0 : st_q.cnt + HALF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the tick counter never passes the half-period limit
    p_cnt_below_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < limit);

    // R2: no tick, no phase progress
    p_no_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run && !tick |=> $stable(st_q.cnt) || !$past(run));

endmodule

// File: rtl/tss_shift_reg.sv
module tss_shift_reg #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_msb,
    input  logic [CNT_W-1:0]  load_n,
    input  logic              sample,
    input  logic              advance,
    input  logic              sdi,
    output logic              sdo,
    output logic [DATA_W-1:0] word_o
);

    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic [CNT_W-1:0]  n;
        logic              msb;
        logic              sdo;
    } shf_st_t;

    shf_st_t           st_d, st_q;
    logic [DATA_W-1:0] mask_q;

    function automatic logic [DATA_W-1:0] low_mask(input logic [CNT_W-1:0] n);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) m[i] = (CNT_W'(i) < n);
        return m;
    endfunction

    function automatic logic lead_bit(input logic [DATA_W-1:0] w,
                                      input logic [CNT_W-1:0]  n,
                                      input logic              msb);
        logic b;
        b = w[0];
        if (msb) begin
            b = 1'b0;
            for (int i = 0; i < DATA_W; i++)
                if (CNT_W'(i) == n - CNT_W'(1)) b = w[i];
        end
        return b;
    endfunction

    always_comb begin
        st_d   = st_q;
        mask_q = low_mask(st_q.n);
        if (load) begin
            st_d.n   = load_n;
            st_d.msb = load_msb;
            st_d.sr  = load_data & low_mask(load_n);
            st_d.sdo = lead_bit(load_data, load_n, load_msb);
        end else begin
            if (sample) begin
                if (st_q.msb) begin
                    st_d.sr = ((st_q.sr << 1) | DATA_W'(sdi)) & mask_q;
                end else begin
                    st_d.sr = st_q.sr >> 1;
                    for (int i = 0; i < DATA_W; i++)
                        if (CNT_W'(i) == st_q.n - CNT_W'(1)) st_d.sr[i] = sdi;
                end
            end
            if (advance) st_d.sdo = lead_bit(st_q.sr, st_q.n, st_q.msb);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sr: '0, n: CNT_W'(DATA_W), msb: 1'b0, sdo: 1'b0};
        else        st_q <= st_d;
    end

    assign sdo    = st_q.sdo;
    assign word_o = st_q.sr;

    // R7: bits above the transfer length stay clear
    p_upper_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sr & ~mask_q) == '0);

    // R6: output bit moves only on load or a return-to-idle edge
    p_sdo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !advance |=> $stable(st_q.sdo));

    // R6: shifting and output advance never coincide
    p_one_action_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample && advance));

endmodule

// File: rtl/tick_serial_shifter.sv
module tick_serial_shifter #(
    parameter int DATA_W = 16,
    parameter int HALF_W = 16,
    parameter int SIZE_W = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    input  logic        tick,
    input  logic        sdi,
    output logic        sclk,
    output logic        sdo,
    output logic        irq
);

    import tss_pkg::*;

    localparam int CNT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        edge_sel_e         mode;
        logic              msb;
        logic [HALF_W-1:0] half;
        logic [SIZE_W-1:0] size;
        logic [DATA_W-1:0] tx;
        logic              busy;
        logic [CNT_W-1:0]  bits;
        logic              sclk;
        logic              idle_lvl;
        logic [HALF_W-1:0] act_half;
        logic              irq;
    } ctl_st_t;

    ctl_st_t           c_d, c_q;
    logic              div_edge;
    logic              start_req, clr_req, mode_ok;
    logic              load_w, sample_w, advance_w, done_w;
    logic [DATA_W-1:0] word_w;

    function automatic logic [CNT_W-1:0] eff_len(input logic [SIZE_W-1:0] s);
        if (int'(s) == 0 || int'(s) > DATA_W) return CNT_W'(DATA_W);
        return CNT_W'(s);
    endfunction

    always_comb begin
        c_d       = c_q;
        load_w    = 1'b0;
        start_req = wr_en && (addr == A_CMD) && wdata[0];
        clr_req   = wr_en && (addr == A_CMD) && wdata[1];
        mode_ok   = (c_q.mode == EDGE_FALL) || (c_q.mode == EDGE_RISE);
        sample_w  = c_q.busy && div_edge && (c_q.sclk == c_q.idle_lvl);
        advance_w = c_q.busy && div_edge && (c_q.sclk != c_q.idle_lvl) && (c_q.bits != '0);
        done_w    = c_q.busy && div_edge && (c_q.sclk != c_q.idle_lvl) && (c_q.bits == '0);

        if (wr_en) begin
            case (addr)
                A_CFG: begin
                    c_d.mode = edge_sel_e'(wdata[1:0]);
                    c_d.msb  = wdata[2];
                end
                A_HALF:  c_d.half = wdata[HALF_W-1:0];
                A_SIZE:  c_d.size = wdata[SIZE_W-1:0];
                A_DATA:  c_d.tx   = wdata[DATA_W-1:0];
                default: ;
            endcase
        end

        if (!c_q.busy) begin
            c_d.sclk = (c_q.mode == EDGE_FALL);
            if (start_req && mode_ok) begin
                c_d.busy     = 1'b1;
                c_d.bits     = eff_len(c_q.size);
                c_d.act_half = c_q.half;
                c_d.idle_lvl = (c_q.mode == EDGE_FALL);
                load_w       = 1'b1;
            end
        end else if (div_edge) begin
            c_d.sclk = ~c_q.sclk;
            if (sample_w)    c_d.bits = c_q.bits - CNT_W'(1);
            else if (done_w) c_d.busy = 1'b0;
        end

        if (clr_req) c_d.irq = 1'b0;
        if (done_w)  c_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    tss_tick_divider #(.HALF_W(HALF_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (c_q.busy),
        .tick   (tick),
        .half_i (c_q.act_half),
        .edge_o (div_edge)
    );

    tss_shift_reg #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_w),
        .load_data (c_q.tx),
        .load_msb  (c_q.msb),
        .load_n    (eff_len(c_q.size)),
        .sample    (sample_w),
        .advance   (advance_w),
        .sdi       (sdi),
        .sdo       (sdo),
        .word_o    (word_w)
    );

    always_comb begin
        case (addr)
            A_CFG:   rdata = 16'({c_q.msb, c_q.mode});
            A_HALF:  rdata = 16'(c_q.half);
            A_SIZE:  rdata = 16'(c_q.size);
            A_DATA:  rdata = 16'(word_w);
            A_CMD:   rdata = 16'({c_q.irq, c_q.busy});
            default: rdata = '0;
        endcase
    end

    assign sclk = c_q.sclk;
    assign irq  = c_q.irq;

    // R8: the end of a transfer always leaves the flag set and sclk idle
    p_done_sets_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(c_q.busy) |-> c_q.irq && (c_q.sclk == c_q.idle_lvl));

    // R9: the flag only drops through a host clear
    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.irq && !clr_req |=> c_q.irq);

    // R10: a start while busy does not reload the bit counter
    p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.busy && start_req && !sample_w |=> $stable(c_q.bits));

    // R11: unsupported edge modes never start a transfer
    p_bad_mode_no_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.busy && start_req && !mode_ok |=> !c_q.busy);

    // R2: sclk only moves on a divider edge while busy
    p_sclk_paced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.busy && !div_edge |=> $stable(c_q.sclk) && c_q.busy);

    // R5: the remaining bit count never exceeds the word width
    p_bits_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(c_q.bits) <= DATA_W);

endmodule

// File: tb/tick_serial_shifter_test.sv
module tick_serial_shifter_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd4;
    logic [15:0] wdata = '0;
    logic        tick = 1'b0;
    logic        inv = 1'b0;
    logic        sdi;
    logic [15:0] rdata;
    logic        sclk, sdo, irq;
    int          vectors = 0;
    int          miscompares = 0;
    bit          reported = 1'b0;

    assign sdi = sdo ^ inv;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_serial_shifter uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tick(tick), .sdi(sdi), .sclk(sclk), .sdo(sdo), .irq(irq)
    );

    function automatic int f_len(input logic [4:0] s);
        return (s == 0 || s > 16) ? 16 : int'(s);
    endfunction

    function automatic logic [15:0] f_mask(input int n);
        return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
    endfunction

    function automatic logic f_bit(input logic [15:0] tx, input int n, input bit msb, input int i);
        return msb ? tx[n-1-i] : tx[i];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 3'd4; wdata = '0;
        #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        addr = a; #1;
        v = rdata;
        addr = 3'd4; #1;
    endtask

    task automatic run_xfer(input logic [1:0] mode, input bit msb, input logic [15:0] half,
                            input logic [4:0] size, input logic [15:0] tx, input bit inv_b,
                            input bit gaps, input bit poke_mid, input bit clr_end);
        int          h, n, total, g;
        logic        idle_l, exp_s;
        logic [15:0] v;
        h      = (half == 0) ? 1 : int'(half);
        n      = f_len(size);
        idle_l = (mode == 2'b01);
        total  = 2 * n * h;
        reg_wr(3'd0, 16'({msb, mode}));
        reg_wr(3'd1, half);
        reg_wr(3'd2, 16'(size));
        reg_wr(3'd3, tx);
        inv = inv_b;
        reg_wr(3'd4, 16'h0001);
        chk("R8 busy after start", 32'(rdata[0]), 32'd1);
        chk("R6 idle level at start", 32'(sclk), 32'(idle_l));
        exp_s = idle_l;
        for (int t = 1; t <= total; t++) begin
            if (gaps) begin
                g = int'($urandom_range(0, 2));
                repeat (g) @(negedge clk);
                if (g > 0) chk("R2 sclk still without tick", 32'(sclk), 32'(exp_s));
            end
            if (poke_mid && t == total / 2 + 1) begin
                reg_wr(3'd4, 16'h0001);
                reg_wr(3'd1, 16'd7);
                reg_wr(3'd2, 16'd3);
                reg_wr(3'd3, ~tx);
                chk("R10 busy kept after mid start", 32'(rdata[0]), 32'd1);
                chk("R10 sclk kept after mid writes", 32'(sclk), 32'(exp_s));
            end
            if ((t % h) == 0 && ((t / h) % 2) == 1)
                chk(msb ? "R4 msb-first output bit" : "R3 lsb-first output bit",
                    32'(sdo), 32'(f_bit(tx, n, msb, (t / h - 1) / 2)));
            tick = 1'b1;
            if (clr_end && t == total) begin
                wr_en = 1'b1; addr = 3'd4; wdata = 16'h0002;
            end
            @(negedge clk);
            tick = 1'b0; wr_en = 1'b0; addr = 3'd4; wdata = '0;
            #1;
            if ((t % h) == 0) exp_s = ~exp_s;
            chk("R2 sclk phase per tick", 32'(sclk), 32'(exp_s));
            if (t == total - 1) chk("R5 busy before last tick", 32'(rdata[0]), 32'd1);
            if (t == total) begin
                chk("R5 busy drop at length", 32'(rdata[0]), 32'd0);
                chk(clr_end ? "R9 set wins over clear" : "R8 irq on completion",
                    32'({irq, rdata[1]}), 32'd3);
                chk("R8 sclk idle after last", 32'(sclk), 32'(idle_l));
            end
        end
        rd(3'd3, v);
        chk("R7 received word", 32'(v), 32'((tx ^ {16{inv_b}}) & f_mask(n)));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL watchdog actual=hung expected=finish");
        if (!reported) begin
            reported = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        end
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 sclk reset", 32'(sclk), 32'd0);
        chk("R1 sdo reset", 32'(sdo), 32'd0);
        chk("R1 irq reset", 32'(irq), 32'd0);
        chk("R1 status reset", 32'(rdata), 32'd0);
        rd(3'd0, v); chk("R1 cfg reset", 32'(v), 32'd0);
        rd(3'd1, v); chk("R1 half reset", 32'(v), 32'd0);
        rd(3'd2, v); chk("R1 size reset", 32'(v), 32'd0);
        rd(3'd3, v); chk("R1 data reset", 32'(v), 32'd0);

        // R11: unsupported edge modes
        reg_wr(3'd0, 16'h0000);
        reg_wr(3'd4, 16'h0001);
        chk("R11 mode 00 start ignored", 32'(rdata[0]), 32'd0);
        reg_wr(3'd0, 16'h0003);
        reg_wr(3'd4, 16'h0001);
        chk("R11 mode 11 start ignored", 32'(rdata[0]), 32'd0);
        @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0; #1;
        chk("R11 sclk quiet", 32'(sclk), 32'd0);

        // R6: idle levels follow mode
        reg_wr(3'd0, 16'h0001);
        @(negedge clk); #1;
        chk("R6 falling mode idles high", 32'(sclk), 32'd1);
        reg_wr(3'd0, 16'h0002);
        @(negedge clk); #1;
        chk("R6 rising mode idles low", 32'(sclk), 32'd0);

        run_xfer(2'b01, 1'b0, 16'd1, 5'd8, 16'h00A5, 1'b0, 1'b0, 1'b0, 1'b0); // R3
        reg_wr(3'd4, 16'h0002);
        chk("R9 clear drops irq", 32'({irq, rdata[1]}), 32'd0);
        run_xfer(2'b10, 1'b1, 16'd3, 5'd5, 16'h0013, 1'b1, 1'b1, 1'b0, 1'b0); // R4
        run_xfer(2'b01, 1'b1, 16'd1, 5'd0, 16'hBEEF, 1'b0, 1'b0, 1'b0, 1'b0); // R5 size 0
        run_xfer(2'b10, 1'b0, 16'd2, 5'd20, 16'h5A3C, 1'b1, 1'b0, 1'b0, 1'b0); // R5 size 20
        run_xfer(2'b10, 1'b0, 16'd0, 5'd4, 16'h0009, 1'b0, 1'b0, 1'b0, 1'b0); // R2 half 0
        run_xfer(2'b01, 1'b0, 16'd2, 5'd6, 16'h002D, 1'b0, 1'b1, 1'b1, 1'b0); // R10
        run_xfer(2'b10, 1'b1, 16'd1, 5'd3, 16'h0005, 1'b0, 1'b0, 1'b0, 1'b1); // R9 same cycle
        reg_wr(3'd4, 16'h0002);
        chk("R9 later clear", 32'({irq, rdata[1]}), 32'd0);
        run_xfer(2'b01, 1'b1, 16'd1, 5'd1, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b0); // R5 one bit
        run_xfer(2'b10, 1'b0, 16'd1, 5'd16, 16'h8001, 1'b0, 1'b0, 1'b0, 1'b0); // R3 full width

        for (int k = 0; k < 25; k++) begin
            if ($urandom_range(0, 1) == 1) reg_wr(3'd4, 16'h0002);
            run_xfer(2'($urandom_range(1, 2)), 1'($urandom_range(0, 1)),
                     16'($urandom_range(1, 4)), 5'($urandom_range(0, 31)),
                     16'($urandom), 1'($urandom_range(0, 1)), 1'b1,
                     (k % 7) == 3, 1'($urandom_range(0, 1)));
        end

        if (!reported) begin
            reported = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        end
        $finish;
    end

endmodule